// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Update Master

This block is the host side of a serial link to a string of identical 16-bit-word DAC devices wired in cascade. Every device's data output feeds the next device's data input. All devices share one serial clock and one active-low select/load line. The host loads one command word per device through a valid/ready write port. It picks, per device, whether the loaded word or a fixed sleep command goes out. A start strobe then launches a transaction that shifts the whole chain in one select window. When the select line rises, every device in the chain updates at the same moment.

The serial clock comes from the system clock through a divider. Every minimum interval the devices need is turned into a cycle count from nanosecond parameters at elaboration time. These intervals are the clock phases, data setup, select lead and lag, and select-high recovery. The serial output of the last device can be looped back. The block then keeps the last returned word and raises a flag when a returned bit differs from the bit it sent one full chain length earlier.

Top module: `dac_chain_master`

## Requirements
- R1: Each transaction holds `cs_n` low for exactly 16·NUM_DEV rising edges of `sck` and raises it once afterwards. `sck` never rises while `cs_n` is high.
- R2: The k-th word written since the previous start (or reset) fills slot k, with k=0 being the device wired directly to `sdo`. The slot of the device farthest down the chain is sent first, most significant bit first. After the transaction, device k therefore holds slot k.
- R3: When `sleep_mask[k]` is 1 at the start strobe, device k receives 16'hE000 (top four bits 1110, the sleep command) in place of its slot.
- R4: `sck` is low whenever `cs_n` is high, including the cycle in which `cs_n` falls.
- R5: `sdo` changes only while `sck` is low. It is stable for at least ceil(T_DIN_SETUP_NS/CLK_PERIOD_NS) cycles before each rising edge of `sck`.
- R6: Each high phase and each low phase of `sck` lasts at least the larger of SCK_HALF cycles and the cycle count of the matching nanosecond minimum.
- R7: From `cs_n` falling to the first `sck` rise is at least ceil(T_CS_LEAD_NS/CLK_PERIOD_NS) cycles. From the last `sck` rise to `cs_n` rising is at least ceil(T_CS_LAG_NS/CLK_PERIOD_NS) cycles. `cs_n` stays high at least ceil(T_CS_IDLE_NS/CLK_PERIOD_NS) cycles between transactions.
- R8: `busy` rises the cycle after an accepted start. It falls after the select-high recovery time, and in that same cycle `done` pulses high for exactly one cycle. A start strobe while `busy` is high is ignored and launches no second transaction.
- R9: `wr_ready` is the inverse of `busy`, and a write offered while `busy` is high changes no slot. The slot pointer wraps modulo NUM_DEV. Slots keep their contents across transactions.
- R10: With loop-back enabled, `rx_word` holds the last 16 bits sampled on `sdi` at `sck` rises. `echo_mismatch` is cleared at start and set when a sampled bit differs from the bit sent 16·NUM_DEV rises earlier. Bits sent before reset count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Command word offered |
| wr_data | input | WORD_W | Command word for the next slot |
| wr_ready | output | 1 | Slot write accepted when high |
| sleep_mask | input | NUM_DEV | Per-device sleep selection, sampled at start |
| start | input | 1 | Launch a chain transaction |
| busy | output | 1 | Transaction or recovery in progress |
| done | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock to all devices |
| cs_n | output | 1 | Shared active-low select/load |
| sdo | output | 1 | Serial data into the first device |
| sdi | input | 1 | Serial data returned from the last device |
| rx_word | output | WORD_W | Last 16 returned bits |
| echo_mismatch | output | 1 | Returned stream disagreed with history |

## Verification
The hardest condition to reach from the ports is a loop-back mismatch. A correct device chain always returns exactly what was sent one chain length earlier, so the flag never rises on its own. The bench therefore keeps a behavioural chain of shift registers and can invert its returned bit for one transaction. It then checks that the flag rises and that a following clean transaction clears it. Ignored inputs are reached by firing a start strobe and a write in the middle of a running transaction. The bench then checks the select-fall count and the slot contents that reach the devices.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_TAIL,
      ST_GAP
   } dcm_state_e;

   localparam logic [3:0] SLEEP_CODE = 4'b1110;

   function automatic int ns2cyc(input int ns, input int period_ns);
      return (ns + period_ns - 1) / period_ns;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dcm_word_store.sv
module dcm_word_store #(
   parameter int NUM_DEV = 3,
   parameter int WORD_W  = 16
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic                      restart,
   output logic [NUM_DEV*WORD_W-1:0] slots
);
   localparam int PTR_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_DEV - 1);

   logic [PTR_W-1:0] ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (restart) begin
         ptr <= '0;
      end else if (wr_en) begin
         ptr <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
      end
   end

   for (genvar k = 0; k < NUM_DEV; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slots[k*WORD_W +: WORD_W] <= '0;
         end else if (wr_en && !restart && ptr == PTR_W'(k)) begin
            slots[k*WORD_W +: WORD_W] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/dcm_frame_shifter.sv
module dcm_frame_shifter #(
   parameter int NUM_DEV = 3,
   parameter int WORD_W  = 16,
   parameter logic [WORD_W-1:0] SLEEP_WORD = '0
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      shift,
   input  logic [NUM_DEV*WORD_W-1:0] slots,
   input  logic [NUM_DEV-1:0]        sleep_mask,
   output logic                      bit_out
);
   localparam int FRAME_W = NUM_DEV * WORD_W;

   logic [FRAME_W-1:0] frame_q;
   logic [FRAME_W-1:0] frame_d;

   // Device k occupies word k; the highest word leaves first.
   for (genvar k = 0; k < NUM_DEV; k++) begin : g_pick
      assign frame_d[k*WORD_W +: WORD_W] =
         sleep_mask[k] ? SLEEP_WORD : slots[k*WORD_W +: WORD_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_q <= '0;
      end else if (load) begin
         frame_q <= frame_d;
      end else if (shift) begin
         frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      end
   end

   assign bit_out = frame_q[FRAME_W-1];
endmodule

// File: rtl/dcm_sequencer.sv
module dcm_sequencer import dcm_pkg::*; #(
   parameter int FRAME_W  = 48,
   parameter int HI_CYC   = 12,
   parameter int LO_CYC   = 12,
   parameter int LEAD_CYC = 20,
   parameter int TAIL_CYC = 1,
   parameter int GAP_CYC  = 19
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic frame_load,
   output logic frame_shift,
   output logic rise_pulse,
   output logic sck,
   output logic cs_n,
   output logic busy,
   output logic done
);
   localparam int MAXC  = max2(max2(max2(HI_CYC, LO_CYC), max2(LEAD_CYC, TAIL_CYC)), GAP_CYC);
   localparam int CNT_W = $clog2(MAXC + 1) + 1;
   localparam int BIT_W = $clog2(FRAME_W + 1);

   dcm_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [BIT_W-1:0] bits_left;
   logic             cnt_zero;

   assign cnt_zero    = (cnt == '0);
   assign frame_load  = (state == ST_IDLE) && start;
   assign rise_pulse  = (state == ST_LEAD || state == ST_LOW) && cnt_zero;
   assign frame_shift = (state == ST_HIGH) && cnt_zero && (bits_left != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         bits_left <= '0;
         sck       <= 1'b0;
         cs_n      <= 1'b1;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cs_n      <= 1'b0;
                  busy      <= 1'b1;
                  bits_left <= BIT_W'(FRAME_W);
                  cnt       <= CNT_W'(LEAD_CYC - 1);
                  state     <= ST_LEAD;
               end
            end
            ST_LEAD, ST_LOW: begin
               if (cnt_zero) begin
                  sck       <= 1'b1;
                  bits_left <= bits_left - BIT_W'(1);
                  cnt       <= CNT_W'(HI_CYC - 1);
                  state     <= ST_HIGH;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_HIGH: begin
               if (cnt_zero) begin
                  sck <= 1'b0;
                  if (bits_left != '0) begin
                     cnt   <= CNT_W'(LO_CYC - 1);
                     state <= ST_LOW;
                  end else begin
                     cnt   <= CNT_W'(TAIL_CYC - 1);
                     state <= ST_TAIL;
                  end
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_TAIL: begin
               if (cnt_zero) begin
                  cs_n  <= 1'b1;
                  cnt   <= CNT_W'(GAP_CYC - 1);
                  state <= ST_GAP;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            ST_GAP: begin
               if (cnt_zero) begin
                  busy  <= 1'b0;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dcm_echo_check.sv
module dcm_echo_check #(
   parameter int FRAME_W = 48,
   parameter int WORD_W  = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              sent_bit,
   input  logic              rx_bit,
   output logic [WORD_W-1:0] rx_word,
   output logic              mismatch
);
   logic [FRAME_W-1:0] history;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         history  <= '0;
         rx_word  <= '0;
         mismatch <= 1'b0;
      end else begin
         if (sample) begin
            history <= {history[FRAME_W-2:0], sent_bit};
            rx_word <= {rx_word[WORD_W-2:0], rx_bit};
         end
         if (clear) begin
            mismatch <= 1'b0;
         end else if (sample && (rx_bit != history[FRAME_W-1])) begin
            mismatch <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master import dcm_pkg::*; #(
   parameter int NUM_DEV        = 3,
   parameter int WORD_W         = 16,
   parameter int CLK_PERIOD_NS  = 5,
   parameter int SCK_HALF       = 12,
   parameter int T_SCK_HIGH_NS  = 50,
   parameter int T_SCK_LOW_NS   = 50,
   parameter int T_DIN_SETUP_NS = 60,
   parameter int T_CS_LEAD_NS   = 100,
   parameter int T_CS_LAG_NS    = 50,
   parameter int T_CS_IDLE_NS   = 100,
   parameter bit LOOPBACK_EN    = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_valid,
   input  logic [WORD_W-1:0]  wr_data,
   output logic               wr_ready,
   input  logic [NUM_DEV-1:0] sleep_mask,
   input  logic               start,
   output logic               busy,
   output logic               done,
   output logic               sck,
   output logic               cs_n,
   output logic               sdo,
   input  logic               sdi,
   output logic [WORD_W-1:0]  rx_word,
   output logic               echo_mismatch
);
   localparam int FRAME_W  = NUM_DEV * WORD_W;
   localparam int HI_CYC   = max2(SCK_HALF, ns2cyc(T_SCK_HIGH_NS, CLK_PERIOD_NS));
   localparam int LO_CYC   = max2(max2(SCK_HALF, ns2cyc(T_SCK_LOW_NS, CLK_PERIOD_NS)),
                                  ns2cyc(T_DIN_SETUP_NS, CLK_PERIOD_NS));
   localparam int LEAD_CYC = max2(max2(1, ns2cyc(T_CS_LEAD_NS, CLK_PERIOD_NS)),
                                  ns2cyc(T_DIN_SETUP_NS, CLK_PERIOD_NS));
   localparam int TAIL_CYC = max2(1, ns2cyc(T_CS_LAG_NS, CLK_PERIOD_NS) - HI_CYC);
   // The idle state adds at least one more select-high cycle.
   localparam int GAP_CYC  = max2(1, ns2cyc(T_CS_IDLE_NS, CLK_PERIOD_NS) - 1);
   localparam logic [WORD_W-1:0] SLEEP_WORD = {SLEEP_CODE, {(WORD_W-4){1'b0}}};

   if (NUM_DEV < 1) begin : g_bad_dev
      $error("NUM_DEV must be at least 1");
   end
   if (WORD_W < 5) begin : g_bad_word
      $error("WORD_W must leave room for the 4-bit command field");
   end
   if (CLK_PERIOD_NS < 1 || SCK_HALF < 1) begin : g_bad_clk
      $error("clock period and SCK divider must be positive");
   end

   logic frame_load;
   logic frame_shift;
   logic rise_pulse;
   logic [FRAME_W-1:0] slots;

   assign wr_ready = !busy;

   dcm_word_store #(
      .NUM_DEV (NUM_DEV),
      .WORD_W  (WORD_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_valid && wr_ready),
      .wr_data (wr_data),
      .restart (frame_load),
      .slots   (slots)
   );

   dcm_frame_shifter #(
      .NUM_DEV    (NUM_DEV),
      .WORD_W     (WORD_W),
      .SLEEP_WORD (SLEEP_WORD)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (frame_load),
      .shift      (frame_shift),
      .slots      (slots),
      .sleep_mask (sleep_mask),
      .bit_out    (sdo)
   );

   dcm_sequencer #(
      .FRAME_W  (FRAME_W),
      .HI_CYC   (HI_CYC),
      .LO_CYC   (LO_CYC),
      .LEAD_CYC (LEAD_CYC),
      .TAIL_CYC (TAIL_CYC),
      .GAP_CYC  (GAP_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .frame_load  (frame_load),
      .frame_shift (frame_shift),
      .rise_pulse  (rise_pulse),
      .sck         (sck),
      .cs_n        (cs_n),
      .busy        (busy),
      .done        (done)
   );

   if (LOOPBACK_EN) begin : g_echo
      dcm_echo_check #(
         .FRAME_W (FRAME_W),
         .WORD_W  (WORD_W)
      ) u_echo (
         .clk      (clk),
         .rst_n    (rst_n),
         .clear    (frame_load),
         .sample   (rise_pulse),
         .sent_bit (sdo),
         .rx_bit   (sdi),
         .rx_word  (rx_word),
         .mismatch (echo_mismatch)
      );
   end else begin : g_no_echo
      assign rx_word       = '0;
      assign echo_mismatch = 1'b0;
   end
endmodule

// File: rtl/dcm_chain_checker.sv
module dcm_chain_checker import dcm_pkg::*; #(
   parameter int CLK_PERIOD_NS = 5,
   parameter int T_SCK_HIGH_NS = 50,
   parameter int T_SCK_LOW_NS  = 50
)(
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic sck,
   input logic cs_n,
   input logic sdo
);
   localparam logic [15:0] HI_MIN = 16'(ns2cyc(T_SCK_HIGH_NS, CLK_PERIOD_NS));
   localparam logic [15:0] LO_MIN = 16'(ns2cyc(T_SCK_LOW_NS, CLK_PERIOD_NS));

   logic        prev_sck;
   logic [15:0] run_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_sck <= 1'b0;
         run_cnt  <= '0;
      end else begin
         prev_sck <= sck;
         if (sck != prev_sck) begin
            run_cnt <= 16'd1;
         end else if (run_cnt != 16'hFFFF) begin
            run_cnt <= run_cnt + 16'd1;
         end
      end
   end

   assert_rise_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> !cs_n);

   assert_sck_low_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   assert_select_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> !$past(sck));

   assert_data_held_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(sdo));

   assert_data_still_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(sdo));

   assert_high_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_sck && !sck) |-> (run_cnt >= HI_MIN));

   assert_low_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!prev_sck && sck) |-> (run_cnt >= LO_MIN));

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

bind dac_chain_master dcm_chain_checker #(
   .CLK_PERIOD_NS (CLK_PERIOD_NS),
   .T_SCK_HIGH_NS (T_SCK_HIGH_NS),
   .T_SCK_LOW_NS  (T_SCK_LOW_NS)
) u_chain_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .busy  (busy),
   .done  (done),
   .sck   (sck),
   .cs_n  (cs_n),
   .sdo   (sdo)
);

// File: tb/dac_chain_master_test.sv
module dac_chain_master_test;
   localparam int M    = 3;
   localparam int W    = 16;
   localparam int PER  = 5;
   localparam int HALF = 12;
   localparam int FW   = M * W;

   localparam int HI_EXP   = (HALF > (50 + PER - 1) / PER) ? HALF : (50 + PER - 1) / PER;
   localparam int LO_EXP   = HI_EXP;
   localparam int SU_EXP   = (60 + PER - 1) / PER;
   localparam int LEAD_EXP = (100 + PER - 1) / PER;
   localparam int LAG_EXP  = (50 + PER - 1) / PER;
   localparam int IDLE_EXP = (100 + PER - 1) / PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic wr_ready;
   logic [M-1:0] sleep_mask = '0;
   logic start = 1'b0;
   logic busy, done, sck, cs_n, sdo, sdi;
   logic [W-1:0] rx_word;
   logic echo_mismatch;
   logic inject = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   dac_chain_master #(
      .NUM_DEV (M), .WORD_W (W), .CLK_PERIOD_NS (PER), .SCK_HALF (HALF),
      .T_SCK_HIGH_NS (50), .T_SCK_LOW_NS (50), .T_DIN_SETUP_NS (60),
      .T_CS_LEAD_NS (100), .T_CS_LAG_NS (50), .T_CS_IDLE_NS (100),
      .LOOPBACK_EN (1'b1)
   ) uut (
      .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_data (wr_data),
      .wr_ready (wr_ready), .sleep_mask (sleep_mask), .start (start),
      .busy (busy), .done (done), .sck (sck), .cs_n (cs_n), .sdo (sdo),
      .sdi (sdi), .rx_word (rx_word), .echo_mismatch (echo_mismatch)
   );

   // Behavioural device chain and port-level timing monitor
   logic [FW-1:0] chain_sr = '0;
   logic [W-1:0]  dev_word [M];
   logic m_sck = 1'b0, m_cs = 1'b1, m_sdo = 1'b0;
   int run_sck = 0, run_cs = 0, run_sdo = 0, since_csfall = 0, since_rise = 0;
   int hi_min = 9999, lo_min = 9999, su_min = 9999, idle_min = 9999;
   int lead_len = 0, lag_len = 0, rises_txn = 0, cs_falls = 0, cs_rises = 0;
   int sdo_viol = 0, sck_cs_viol = 0;

   assign sdi = chain_sr[FW-1] ^ inject;

   always @(negedge clk) begin
      if (!rst_n) begin
         chain_sr = '0;
         m_sck = 1'b0; m_cs = 1'b1; m_sdo = 1'b0;
         run_sck = 0; run_cs = 0; run_sdo = 0;
      end else begin
         run_sck++; run_cs++; run_sdo++; since_csfall++; since_rise++;
         if (sck !== m_sck) begin
            if (m_sck && !sck && run_sck < hi_min) hi_min = run_sck;
            if (!m_sck && sck) begin
               if (rises_txn == 0) lead_len = since_csfall;
               else if (run_sck < lo_min) lo_min = run_sck;
               if (run_sdo < su_min) su_min = run_sdo;
               if (cs_n) sck_cs_viol++;
               else chain_sr = {chain_sr[FW-2:0], sdo};
               rises_txn++;
               since_rise = 0;
            end
            run_sck = 0;
         end
         if (sdo !== m_sdo) begin
            if (m_sck && sck) sdo_viol++;
            run_sdo = 0;
         end
         if (cs_n && sck) sck_cs_viol++;
         if (cs_n !== m_cs) begin
            if (!cs_n) begin
               if (sck) sck_cs_viol++;
               if (cs_falls > 0 && run_cs < idle_min) idle_min = run_cs;
               cs_falls++;
               rises_txn = 0;
               since_csfall = 0;
               hi_min = 9999; lo_min = 9999; su_min = 9999;
            end else begin
               lag_len = since_rise;
               cs_rises++;
               for (int k = 0; k < M; k++) dev_word[k] = chain_sr[k*W +: W];
            end
            run_cs = 0;
         end
         m_sck = sck; m_cs = cs_n; m_sdo = sdo;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Bench view of the slot store
   logic [W-1:0] slot_exp [M];
   int ptr = 0;
   logic [W-1:0] prev_dev0 = '0;

   function automatic logic [W-1:0] pat(input int t, input int k);
      return W'((t * 937 + k * 4369 + 3855) ^ (t << 12) ^ (k << 7));
   endfunction

   task automatic write_word(input logic [W-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_data = d;
      check(wr_ready == 1'b1, "R9", "ready while idle", wr_ready, 1);
      @(negedge clk);
      wr_valid = 1'b0;
      slot_exp[ptr] = d;
      ptr = (ptr + 1) % M;
   endtask

   task automatic run_txn(input logic [M-1:0] mask, input bit mid_start,
                          input bit junk_write, input bit corrupt);
      int f0;
      int n;
      logic [W-1:0] exp;
      f0 = cs_falls;
      inject = corrupt;
      @(negedge clk);
      sleep_mask = mask; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ptr = 0;
      check(busy == 1'b1, "R8", "busy after start", busy, 1);
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
         if (n == 100 && mid_start) start = 1'b1;
         if (n == 101) start = 1'b0;
         if (n == 150 && junk_write) begin
            check(wr_ready == 1'b0, "R9", "ready while busy", wr_ready, 0);
            wr_valid = 1'b1; wr_data = 16'hDEAD;
         end
         if (n == 151) wr_valid = 1'b0;
         if (!done) check(busy == 1'b1, "R8", "busy held", busy, 1);
      end
      check(done == 1'b1, "R8", "done seen", done, 1);
      check(busy == 1'b0, "R8", "busy low at done", busy, 0);
      @(negedge clk);
      check(done == 1'b0, "R8", "done one cycle", done, 0);
      inject = 1'b0;
      repeat (30) @(negedge clk);
      check(cs_falls == f0 + 1, "R8", "select falls", cs_falls - f0, 1);
      check(cs_rises == f0 + 1, "R1", "select rises", cs_rises - f0, 1);
      check(rises_txn == FW, "R1", "sck rises", rises_txn, FW);
      for (int k = 0; k < M; k++) begin
         exp = mask[k] ? 16'hE000 : slot_exp[k];
         check(dev_word[k] == exp, mask[k] ? "R3" : "R2", "device word", dev_word[k], exp);
      end
      check(sck_cs_viol == 0, "R4", "sck high while deselected", sck_cs_viol, 0);
      check(sdo_viol == 0, "R5", "data moved while sck high", sdo_viol, 0);
      check(su_min >= SU_EXP, "R5", "data setup", su_min, SU_EXP);
      check(hi_min >= HI_EXP, "R6", "high phase", hi_min, HI_EXP);
      check(lo_min >= LO_EXP, "R6", "low phase", lo_min, LO_EXP);
      check(lead_len >= LEAD_EXP, "R7", "select lead", lead_len, LEAD_EXP);
      check(lag_len >= LAG_EXP, "R7", "select lag", lag_len, LAG_EXP);
      exp = corrupt ? ~prev_dev0 : prev_dev0;
      check(rx_word == exp, "R10", "returned word", rx_word, exp);
      check(echo_mismatch == corrupt, "R10", "mismatch flag", echo_mismatch, corrupt);
      prev_dev0 = mask[0] ? 16'hE000 : slot_exp[0];
   endtask

   initial begin
      for (int k = 0; k < M; k++) slot_exp[k] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cs_n == 1'b1, "R4", "reset select", cs_n, 1);
      check(sck == 1'b0, "R4", "reset sck", sck, 0);
      check(busy == 1'b0, "R8", "reset busy", busy, 0);
      check(done == 1'b0, "R8", "reset done", done, 0);
      check(wr_ready == 1'b1, "R9", "reset ready", wr_ready, 1);
      check(rx_word == '0, "R10", "reset rx word", rx_word, 0);
      check(echo_mismatch == 1'b0, "R10", "reset mismatch", echo_mismatch, 0);

      // every sleep mask with fresh words (R2, R3)
      for (int t = 0; t < 8; t++) begin
         for (int k = 0; k < M; k++) write_word(pat(t, k));
         run_txn(M'(t), 1'b0, 1'b0, 1'b0);
      end
      // start strobe while busy is ignored (R8)
      for (int k = 0; k < M; k++) write_word(pat(8, k));
      run_txn('0, 1'b1, 1'b0, 1'b0);
      // write while busy is ignored (R9)
      for (int k = 0; k < M; k++) write_word(pat(9, k));
      run_txn('0, 1'b0, 1'b1, 1'b0);
      // pointer wrap: four writes, slot 0 overwritten (R9)
      for (int k = 0; k < M + 1; k++) write_word(pat(10, k));
      run_txn(3'b010, 1'b0, 1'b0, 1'b0);
      // slots retained with no writes (R9)
      run_txn('0, 1'b0, 1'b0, 1'b0);
      // corrupted return, then clean (R10)
      for (int k = 0; k < M; k++) write_word(pat(11, k));
      run_txn('0, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < M; k++) write_word(pat(12, k));
      run_txn(3'b100, 1'b0, 1'b0, 1'b0);
      // back-to-back starts: select-high recovery (R7)
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!done) @(negedge clk);
      repeat (30) @(negedge clk);
      check(idle_min >= IDLE_EXP, "R7", "select idle", idle_min, IDLE_EXP);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL R8 watchdog: actual %0d expected %0d", wd, 150000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule